// File: doc/BRIEF.md
# Test Coprocessor: Stall Timer, Delayed Interrupts and Timestamps

This block is a coprocessor for processor validation. It holds sixteen 32-bit registers. Software reaches them through register moves and through load/store data beats, which may be single or multi-word. Data-processing commands use those registers as operands, and there are six of them:
- stall the processor for a programmed number of cycles;
- schedule an active-low fast interrupt request after a programmed delay;
- schedule an active-low normal interrupt request after a programmed delay;
- clear the fast interrupt request;
- clear the normal interrupt request;
- copy a free-running cycle count into a register.

The host core delivers one decoded request per cycle: a kind, a phase (first, busy poll or data beat), the instruction word, write data and its own cycle count. One cycle later the block answers with a registered status code and read data. The two interrupt lines are registered outputs that the block drives on its own. Memory addressing for multi-word transfers belongs to the host.

Top module: `tcop_unit`

## Requirements
- R1: Each cycle with `req_valid` high is answered by `rsp_valid` high in the next cycle, and only then. `rsp_status` codes are: 0 done, 1 busy, 2 reject, 3 more.
- R2: The request kinds are 0 move-to, 1 move-from, 2 load, 3 store and 4 data-processing. Move-to writes `req_wdata` into the register at instruction bits 19:16. Move-from returns that register on `rsp_rdata`. Both answer done.
- R3: Phase codes are 0 first, 1 busy and 2 data. A load or store data beat uses the register at bits 15:12. A load beat writes `req_wdata` into it. A store beat returns it. With bit 22 clear, every beat answers done.
- R4: With bit 22 set, a first-phase load/store answers done and restarts the beat count. After that, data beats answer more until the LONG_BEATS-th beat, which answers done.
- R5: Data-processing opcode 0 (bits 23:20) reads its delay from the register at bits 3:0. If that delay is zero, the first phase answers done.
- R6: For opcode 0 with delay d > 0, the first phase at count T answers busy and records finish = T + d. A busy-phase poll at count N answers busy while N - finish, taken modulo 2^32, is negative as a signed value. Otherwise it answers done. This holds across wraparound of the count.
- R7: Opcode 1 with delay 0 drives `n_fiq` low in the cycle after the request. With delay d > 0, `n_fiq` goes low d cycles after that.
- R8: Opcode 2 does the same to `n_irq`, and each line leaves the other unaffected.
- R9: Opcode 3 raises `n_fiq` and opcode 4 raises `n_irq`; each also cancels a pending delayed assertion. A new request on a line reloads its delay count.
- R10: Opcode 5 writes `cycle_now` into the register at bits 3:0.
- R11: The following are answered reject and change no register or line:
  - opcodes 6 to 15;
  - request kinds 5 to 7.
- R12: After reset, `rsp_valid` is 0 and both interrupt lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 3 | Request kind (R2 encoding) |
| req_phase | input | 2 | First / busy poll / data beat |
| req_instr | input | 32 | Decoded instruction word |
| req_wdata | input | DATA_W | Data for move-to and load beats |
| cycle_now | input | DATA_W | Host free-running cycle count |
| rsp_valid | output | 1 | Response is valid |
| rsp_status | output | 2 | Done / busy / reject / more |
| rsp_rdata | output | DATA_W | Data for move-from and store beats |
| n_fiq | output | 1 | Active-low fast interrupt request |
| n_irq | output | 1 | Active-low normal interrupt request |

## Verification
The properties assume several things about the inputs:
- a busy-phase poll only ever follows an opcode-0 first phase;
- `cycle_now` never runs more than 2^31 past a recorded finish;
- a stall delay stays below 2^31;
- the phase code is never 3.

The directed stimulus keeps delays to a few dozen cycles and drives `cycle_now` explicitly from the bench. The wraparound case places the finish just past zero, so that the count moves from 0xFFFFFFF0 to small values. Clear and set for one line can never coincide, because they are different opcodes of a single request.

// File: rtl/tcop_pkg.sv
package tcop_pkg;
  typedef enum logic [2:0] {
    K_MOVE_TO   = 3'd0,
    K_MOVE_FROM = 3'd1,
    K_LOAD      = 3'd2,
    K_STORE     = 3'd3,
    K_CDP       = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_BUSY  = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ST_DONE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_REJECT = 2'd2,
    ST_MORE   = 2'd3
  } status_e;

  localparam logic [3:0] OP_WAIT    = 4'd0;
  localparam logic [3:0] OP_FIQ_SET = 4'd1;
  localparam logic [3:0] OP_IRQ_SET = 4'd2;
  localparam logic [3:0] OP_FIQ_CLR = 4'd3;
  localparam logic [3:0] OP_IRQ_CLR = 4'd4;
  localparam logic [3:0] OP_STAMP   = 4'd5;
endpackage

// File: rtl/tcop_regfile.sv
module tcop_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/tcop_stall.sv
module tcop_stall #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] delay,
  input  logic [W-1:0] now,
  output logic         reached
);
  logic [W-1:0] finish_q;
  logic [W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)        finish_q <= '0;
    else if (start) finish_q <= now + delay;
  end

  // Modular distance: sign bit set means the finish point lies ahead.
  assign gap     = now - finish_q;
  assign reached = ~gap[W-1];

  // R6: a stall is only armed with a nonzero delay below half the count range.
  p_arm_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> (delay != '0 && !delay[W-1]));
endmodule

// File: rtl/tcop_irq_line.sv
module tcop_irq_line #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_req,
  input  logic             clr_req,
  input  logic [CNT_W-1:0] delay,
  output logic             n_line
);
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_line <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_req) begin
      n_line <= 1'b1;
      pend_q <= 1'b0;
    end else if (set_req) begin
      if (delay == '0) begin
        n_line <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        cnt_q  <= delay;
        pend_q <= 1'b1;
      end
    end else if (pend_q) begin
      if (cnt_q == CNT_W'(1)) begin
        n_line <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R9: a clear always leaves the line high.
  p_clear_raises_r9: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> n_line);

  // R7 and R8: zero delay asserts in the next cycle.
  p_zero_delay_r7: assert property (@(posedge clk) disable iff (rst)
    (set_req && !clr_req && delay == '0) |=> !n_line);

  // R7 and R8: the line only falls because of a request or an expiring wait.
  p_fall_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(n_line) |-> ($past(set_req) || $past(pend_q)));
endmodule

// File: rtl/tcop_unit.sv
module tcop_unit
  import tcop_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NREGS      = 16,
  parameter int LONG_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [1:0]        req_phase,
  input  logic [31:0]       req_instr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] cycle_now,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              n_fiq,
  output logic              n_irq
);
  localparam int AW      = $clog2(NREGS);
  localparam int BEAT_W  = $clog2(LONG_BEATS + 1);
  localparam int N_LINES = 2;

  kind_e             kind;
  phase_e            phase;
  logic [3:0]        opcode;
  logic              is_long;
  logic [AW-1:0]     mov_idx, ls_idx, opd_idx;
  logic              instr_unused;

  logic              we;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wdata;
  logic [AW-1:0]     ra_addr;
  logic [DATA_W-1:0] ra_data, delay_val;

  logic [BEAT_W-1:0] beat_q, beat_n;
  status_e           st_n, st_q;
  logic [DATA_W-1:0] rdata_n;
  logic              stall_start, stall_reached;
  logic [N_LINES-1:0] set_req, clr_req, line_n;

  assign kind         = kind_e'(req_kind);
  assign phase        = phase_e'(req_phase);
  assign opcode       = req_instr[23:20];
  assign is_long      = req_instr[22];
  assign mov_idx      = req_instr[16 +: AW];
  assign ls_idx       = req_instr[12 +: AW];
  assign opd_idx      = req_instr[0 +: AW];
  assign instr_unused = ^{req_instr[31:24], req_instr[11:4]};

  tcop_regfile #(.W(DATA_W), .DEPTH(NREGS)) u_regs (
    .clk     (clk),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .ra_addr (ra_addr),
    .ra_data (ra_data),
    .rb_addr (opd_idx),
    .rb_data (delay_val)
  );

  tcop_stall #(.W(DATA_W)) u_stall (
    .clk     (clk),
    .rst     (rst),
    .start   (stall_start),
    .delay   (delay_val),
    .now     (cycle_now),
    .reached (stall_reached)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    tcop_irq_line #(.CNT_W(DATA_W)) u_line (
      .clk     (clk),
      .rst     (rst),
      .set_req (set_req[g]),
      .clr_req (clr_req[g]),
      .delay   (delay_val),
      .n_line  (line_n[g])
    );
  end

  assign n_fiq = line_n[0];
  assign n_irq = line_n[1];

  always_comb begin
    st_n        = ST_DONE;
    rdata_n     = '0;
    we          = 1'b0;
    waddr       = mov_idx;
    wdata       = req_wdata;
    beat_n      = beat_q;
    stall_start = 1'b0;
    set_req     = '0;
    clr_req     = '0;
    ra_addr     = (kind == K_STORE) ? ls_idx : mov_idx;
    if (req_valid) begin
      case (kind)
        K_MOVE_TO:   we = 1'b1;
        K_MOVE_FROM: rdata_n = ra_data;
        K_LOAD, K_STORE: begin
          if (phase == PH_FIRST) begin
            beat_n = '0;
          end else if (phase == PH_DATA) begin
            if (kind == K_LOAD) begin
              we    = 1'b1;
              waddr = ls_idx;
            end else begin
              rdata_n = ra_data;
            end
            if (is_long) begin
              if (beat_q == BEAT_W'(LONG_BEATS - 1)) begin
                beat_n = '0;
              end else begin
                beat_n = beat_q + 1'b1;
                st_n   = ST_MORE;
              end
            end
          end
        end
        K_CDP: begin
          case (opcode)
            OP_WAIT: begin
              if (phase == PH_FIRST) begin
                if (delay_val != '0) begin
                  stall_start = 1'b1;
                  st_n        = ST_BUSY;
                end
              end else if (phase == PH_BUSY) begin
                st_n = stall_reached ? ST_DONE : ST_BUSY;
              end
            end
            OP_FIQ_SET: set_req[0] = (phase == PH_FIRST);
            OP_IRQ_SET: set_req[1] = (phase == PH_FIRST);
            OP_FIQ_CLR: clr_req[0] = (phase == PH_FIRST);
            OP_IRQ_CLR: clr_req[1] = (phase == PH_FIRST);
            OP_STAMP: begin
              if (phase == PH_FIRST) begin
                we    = 1'b1;
                waddr = opd_idx;
                wdata = cycle_now;
              end
            end
            default: st_n = ST_REJECT;
          endcase
        end
        default: st_n = ST_REJECT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      st_q      <= ST_DONE;
      rsp_rdata <= '0;
      beat_q    <= '0;
    end else begin
      rsp_valid <= req_valid;
      beat_q    <= beat_n;
      if (req_valid) begin
        st_q      <= st_n;
        rsp_rdata <= rdata_n;
      end
    end
  end

  assign rsp_status = st_q;

  // R1: one response per request, one cycle later.
  p_resp_follows_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R6: busy is only ever reported for a stall command.
  p_busy_only_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && st_q == ST_BUSY) |->
      $past(req_kind == 3'(K_CDP) && req_instr[23:20] == OP_WAIT));

  // R4: "more" only answers a long data beat.
  p_more_only_long_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && st_q == ST_MORE) |->
      $past(req_instr[22] && req_phase == 2'(PH_DATA)));
endmodule

// File: tb/tb_tcop_unit.sv
module tb_tcop_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LB = 4;

  localparam logic [2:0] KMT = 3'd0, KMF = 3'd1, KLD = 3'd2, KST = 3'd3, KCD = 3'd4;
  localparam logic [1:0] PF = 2'd0, PB = 2'd1, PD = 2'd2;
  localparam logic [1:0] SDONE = 2'd0, SBUSY = 2'd1, SREJ = 2'd2, SMORE = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [1:0]  req_phase = '0;
  logic [31:0] req_instr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] cycle_now = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        n_fiq, n_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic        g_valid;
  logic [1:0]  g_status;
  logic [31:0] g_rdata;

  tcop_unit #(.DATA_W(32), .NREGS(16), .LONG_BEATS(LB)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_phase(req_phase), .req_instr(req_instr), .req_wdata(req_wdata),
    .cycle_now(cycle_now), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .n_fiq(n_fiq), .n_irq(n_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] f_mov(input int r);
    return 32'(r) << 16;
  endfunction
  function automatic logic [31:0] f_ls(input int r, input bit lng);
    return (32'(r) << 12) | (32'(lng) << 22);
  endfunction
  function automatic logic [31:0] f_op(input int op, input int r);
    return (32'(op) << 20) | 32'(r);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with the response.
  task automatic issue(input logic [2:0] k, input logic [1:0] ph,
                       input logic [31:0] ins, input logic [31:0] wd);
    req_kind  = k;
    req_phase = ph;
    req_instr = ins;
    req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    g_valid  = rsp_valid;
    g_status = rsp_status;
    g_rdata  = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic put(input int r, input logic [31:0] v);
    issue(KMT, PF, f_mov(r), v);
  endtask

  task automatic t_reset;
    chk("R12 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R12 n_fiq after reset", 32'(n_fiq), 32'd1);
    chk("R12 n_irq after reset", 32'(n_irq), 32'd1);
  endtask

  task automatic t_moves;
    put(3, 32'hDEADBEEF);
    chk("R1 valid after move-to", 32'(g_valid), 32'd1);
    chk("R1 move-to done", 32'(g_status), 32'(SDONE));
    put(12, 32'h0000_1234);
    issue(KMF, PF, f_mov(3), '0);
    chk("R2 read r3", g_rdata, 32'hDEADBEEF);
    issue(KMF, PF, f_mov(12), '0);
    chk("R2 read r12", g_rdata, 32'h0000_1234);
    chk("R2 move-from done", 32'(g_status), 32'(SDONE));
    @(negedge clk);
    chk("R1 no response when idle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_short_ls;
    issue(KLD, PD, f_ls(5, 0), 32'h0000_A5A5);
    chk("R3 short load done", 32'(g_status), 32'(SDONE));
    issue(KST, PD, f_ls(5, 0), '0);
    chk("R3 short store data", g_rdata, 32'h0000_A5A5);
    chk("R3 short store done", 32'(g_status), 32'(SDONE));
    issue(KMF, PF, f_mov(5), '0);
    chk("R3 load wrote r5", g_rdata, 32'h0000_A5A5);
  endtask

  task automatic t_long_ls;
    issue(KLD, PF, f_ls(7, 1), '0);
    chk("R4 long load first done", 32'(g_status), 32'(SDONE));
    for (int k = 0; k < LB; k++) begin
      issue(KLD, PD, f_ls(7, 1), 32'h100 + 32'(k));
      chk($sformatf("R4 long load beat %0d", k), 32'(g_status),
          (k == LB-1) ? 32'(SDONE) : 32'(SMORE));
    end
    issue(KST, PF, f_ls(7, 1), '0);
    for (int k = 0; k < LB; k++) begin
      issue(KST, PD, f_ls(7, 1), '0);
      chk($sformatf("R4 long store beat %0d", k), 32'(g_status),
          (k == LB-1) ? 32'(SDONE) : 32'(SMORE));
      chk("R3 long store data", g_rdata, 32'h100 + 32'(LB-1));
    end
    // restart part way through
    issue(KLD, PF, f_ls(8, 1), '0);
    issue(KLD, PD, f_ls(8, 1), 32'h1);
    issue(KLD, PD, f_ls(8, 1), 32'h2);
    issue(KLD, PF, f_ls(8, 1), '0);
    chk("R4 restart first done", 32'(g_status), 32'(SDONE));
    for (int k = 0; k < LB; k++) begin
      issue(KLD, PD, f_ls(8, 1), 32'h9);
      chk($sformatf("R4 restarted beat %0d", k), 32'(g_status),
          (k == LB-1) ? 32'(SDONE) : 32'(SMORE));
    end
  endtask

  task automatic t_wait;
    put(1, 32'd0);
    issue(KCD, PF, f_op(0, 1), '0);
    chk("R5 zero stall done", 32'(g_status), 32'(SDONE));
    put(2, 32'd5);
    cycle_now = 32'd100;
    issue(KCD, PF, f_op(0, 2), '0);
    chk("R6 stall first busy", 32'(g_status), 32'(SBUSY));
    cycle_now = 32'd103;
    issue(KCD, PB, f_op(0, 2), '0);
    chk("R6 stall poll early busy", 32'(g_status), 32'(SBUSY));
    cycle_now = 32'd105;
    issue(KCD, PB, f_op(0, 2), '0);
    chk("R6 stall poll reached done", 32'(g_status), 32'(SDONE));
    put(2, 32'h20);
    cycle_now = 32'hFFFF_FFF0;
    issue(KCD, PF, f_op(0, 2), '0);
    chk("R6 wrap first busy", 32'(g_status), 32'(SBUSY));
    cycle_now = 32'hFFFF_FFF8;
    issue(KCD, PB, f_op(0, 2), '0);
    chk("R6 wrap poll before zero busy", 32'(g_status), 32'(SBUSY));
    cycle_now = 32'h0000_0005;
    issue(KCD, PB, f_op(0, 2), '0);
    chk("R6 wrap poll after zero busy", 32'(g_status), 32'(SBUSY));
    cycle_now = 32'h0000_0010;
    issue(KCD, PB, f_op(0, 2), '0);
    chk("R6 wrap poll reached done", 32'(g_status), 32'(SDONE));
  endtask

  task automatic t_fiq;
    put(1, 32'd0);
    put(4, 32'd3);
    issue(KCD, PF, f_op(1, 1), '0);
    chk("R7 zero-delay fiq low", 32'(n_fiq), 32'd0);
    chk("R8 irq untouched by fiq", 32'(n_irq), 32'd1);
    issue(KCD, PF, f_op(3, 1), '0);
    chk("R9 fiq clear raises", 32'(n_fiq), 32'd1);
    issue(KCD, PF, f_op(1, 4), '0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 delayed fiq still high", 32'(n_fiq), 32'd1);
    @(negedge clk);
    chk("R7 delayed fiq low at d", 32'(n_fiq), 32'd0);
    issue(KCD, PF, f_op(3, 4), '0);
  endtask

  task automatic t_irq;
    issue(KCD, PF, f_op(2, 4), '0);
    @(negedge clk);
    @(negedge clk);
    chk("R8 delayed irq still high", 32'(n_irq), 32'd1);
    @(negedge clk);
    chk("R8 delayed irq low at d", 32'(n_irq), 32'd0);
    chk("R8 fiq untouched by irq", 32'(n_fiq), 32'd1);
    issue(KCD, PF, f_op(4, 4), '0);
    chk("R9 irq clear raises", 32'(n_irq), 32'd1);
  endtask

  task automatic t_cancel;
    issue(KCD, PF, f_op(1, 4), '0);
    issue(KCD, PF, f_op(3, 4), '0);
    for (int k = 0; k < 5; k++) @(negedge clk);
    chk("R9 clear cancels pending fiq", 32'(n_fiq), 32'd1);
    put(6, 32'd4);
    issue(KCD, PF, f_op(1, 4), '0);
    @(negedge clk);
    issue(KCD, PF, f_op(1, 6), '0);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk($sformatf("R9 reload fiq after %0d", k), 32'(n_fiq),
          (k == 4) ? 32'd0 : 32'd1);
    end
    issue(KCD, PF, f_op(3, 4), '0);
  endtask

  task automatic t_stamp;
    cycle_now = 32'hCAFE_0001;
    issue(KCD, PF, f_op(5, 9), '0);
    chk("R10 stamp done", 32'(g_status), 32'(SDONE));
    issue(KMF, PF, f_mov(9), '0);
    chk("R10 stamp value", g_rdata, 32'hCAFE_0001);
  endtask

  task automatic t_reject;
    cycle_now = 32'h1111_2222;
    issue(KCD, PF, f_op(7, 9), 32'h5555_5555);
    chk("R11 opcode 7 reject", 32'(g_status), 32'(SREJ));
    issue(KCD, PF, f_op(15, 9), 32'h5555_5555);
    chk("R11 opcode 15 reject", 32'(g_status), 32'(SREJ));
    issue(3'd6, PF, f_mov(9) | f_ls(9, 0), 32'h5555_5555);
    chk("R11 kind 6 reject", 32'(g_status), 32'(SREJ));
    chk("R11 fiq unchanged", 32'(n_fiq), 32'd1);
    chk("R11 irq unchanged", 32'(n_irq), 32'd1);
    issue(KMF, PF, f_mov(9), '0);
    chk("R11 r9 unchanged", g_rdata, 32'hCAFE_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_moves();
    t_short_ls();
    t_long_ls();
    t_wait();
    t_fiq();
    t_irq();
    t_cancel();
    t_stamp();
    t_reject();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule